// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets clocked logic use an external asynchronous static RAM of 32K bytes that shares one bidirectional data bus for reads and writes. The user side issues a single-cycle request with a direction flag, a 15-bit address and, for writes, a byte of data. The block then runs a fixed sequence of phases on the memory pins and reports completion with a one-cycle done pulse. For reads, the captured byte is presented alongside that pulse.

Every phase length is a whole number of clock cycles. Each length is derived at elaboration from the memory's minimum timing in nanoseconds and the clock period. Writes are framed by the write-enable strobe. Output enable stays high for the whole write, and the block's own bus drivers are on only while write enable is low. Reads are framed by output enable. Each read is followed by an idle turnaround, so the block never drives the bus while the memory might still be driving it.

The memory-side data bus is split into an output value, a drive enable and an input value. A pad cell or a tristate wrapper outside the block joins them onto the shared pins.

Top module: `asram_port`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, the outputs `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` and `done` are 0.
- R2: A write runs in three phases. First comes one setup cycle with `mem_ce_n`=0, `mem_we_n`=1 and the address valid. Then `mem_we_n`=0 for WR_CYC cycles. Then one end cycle with `mem_we_n`=1 and `mem_ce_n` still 0. `mem_oe_n` stays 1 for the whole write.
- R3: `mem_dq_oe` is 1 exactly in the cycles where `mem_we_n` is 0, and `mem_dq_o` then carries the request's write byte.
- R4: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles. `rd_data` is registered from `mem_dq_i` on the clock edge that ends the last of those cycles. `mem_oe_n` returns to 1 on that same edge.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R6: Every accepted request produces exactly one `done` pulse of one cycle. For a write, the pulse falls in the end cycle. For a read, it falls in the cycle after output enable rises, and `rd_data` holds the read byte at that time. So done appears 2+WR_CYC cycles after a write is accepted and 1+RD_CYC cycles after a read is accepted.
- R7: After a read's done cycle, at least TURN_CYC cycles follow with `mem_ce_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0 before the block accepts a new request.
- R8: A request is accepted only in the idle state. A `req` raised while a cycle is in progress, or during turnaround, is ignored: it yields no done pulse and no memory access.
- R9: `mem_addr` stays constant from the start of a cycle until after its strobe, write enable or output enable, has returned high.
- R10: WR_CYC is the largest of the write pulse, data setup and address-to-end-of-write minima. RD_CYC is the larger of the address access and output-enable access minima. Each minimum becomes a cycle count as ceil(ns / CLK_NS), with a floor of 1. The defaults (10 ns clock; 9, 8, 10, 12 and 7 ns minima) give WR_CYC=1 and RD_CYC=2.
- R11: While `mem_dq_oe` is 1, `mem_dq_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request pulse, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte captured by the last read |
| mem_addr | output | ADDR_W | Address lines to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the shared data bus |
| mem_dq_i | input | DATA_W | Data received from the shared bus |

## Verification
A sequencer stuck in the wrong phase shows up at once on the strobe pins. A write enable low with chip enable high, a drive enable that overlaps output enable, or an address that moves under a strobe is visible in the very cycle it happens. A phase counter loaded with the wrong value moves the done pulse by whole cycles, and the bench times done against the cycle counts derived in R10. A capture edge taken too early returns the memory model's filler byte instead of the stored byte, and a skipped turnaround shows on the first cycle after a read's done.

// File: rtl/asram_pkg.sv
// Shared types and elaboration-time helpers for the static RAM sequencer.
// Assumes integer nanosecond timing and an integer clock period.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WSTB,
        ST_WEND,
        ST_RACC,
        ST_REND,
        ST_TURN
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
        logic done;
    } pin_ctl_t;

    // Cycles needed to cover a nanosecond minimum, never below one.
    function automatic int cyc_of(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Largest of three counts.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    // Memory pin levels that belong to each phase.
    function automatic pin_ctl_t ctl_for(input seq_state_t s);
        pin_ctl_t p;
        p.ce_n = 1'b1;
        p.oe_n = 1'b1;
        p.we_n = 1'b1;
        p.drv  = 1'b0;
        p.done = 1'b0;
        case (s)
            ST_WSET: p.ce_n = 1'b0;
            ST_WSTB: begin
                p.ce_n = 1'b0;
                p.we_n = 1'b0;
                p.drv  = 1'b1;
            end
            ST_WEND: begin
                p.ce_n = 1'b0;
                p.done = 1'b1;
            end
            ST_RACC: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            ST_REND: begin
                p.ce_n = 1'b0;
                p.done = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Phase length down-counter.
// On load it takes (length - 1) and counts down to zero; last is high at zero.
// Assumes the sequencer loads it on the edge that enters a timed phase.
module asram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Load a phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_rdcap.sv
// Read data capture register.
// Samples the memory bus on the strobe edge and holds the value until the next read.
// Assumes the capture strobe arrives only while output enable is still low.
module asram_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Register the bus byte at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end
endmodule

// File: rtl/asram_seq.sv
// Phase sequencer for write and read cycles.
// Latches a request in idle, steps through the setup, strobe, end and
// turnaround phases, and registers the memory pin levels of the next phase.
// Assumes WR_CYC, RD_CYC and TURN_CYC are at least 1 and fit in CNT_W bits.
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int WR_CYC   = 1,
    parameter int RD_CYC   = 2,
    parameter int TURN_CYC = 1,
    parameter int CNT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              capture,
    output pin_ctl_t          ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    seq_state_t state_q, state_d;
    logic       accept;

    // Next phase, timer loads and capture strobe.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        accept   = 1'b0;
        case (state_q)
            ST_IDLE: if (req) begin
                accept = 1'b1;
                if (req_wr) begin
                    state_d = ST_WSET;
                end else begin
                    state_d  = ST_RACC;
                    tmr_load = 1'b1;
                    tmr_val  = RD_LOAD;
                end
            end
            ST_WSET: begin
                state_d  = ST_WSTB;
                tmr_load = 1'b1;
                tmr_val  = WR_LOAD;
            end
            ST_WSTB: if (tmr_last) state_d = ST_WEND;
            ST_WEND: state_d = ST_IDLE;
            ST_RACC: if (tmr_last) begin
                capture = 1'b1;
                state_d = ST_REND;
            end
            ST_REND: begin
                state_d  = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = TURN_LOAD;
            end
            ST_TURN: if (tmr_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register and registered pin levels of the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= ctl_for(ST_IDLE);
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_for(state_d);
        end
    end

    // Hold address and write byte for the whole accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end
endmodule

// File: rtl/asram_port.sv
// Top of the static RAM sequencer.
// Derives phase lengths from the memory's nanosecond minima and the clock period,
// and joins the sequencer, the phase timer and the read capture register.
// Assumes an external pad joins mem_dq_o, mem_dq_oe and mem_dq_i onto the shared bus.
module asram_port
    import asram_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int T_WP_NS  = 9,
    parameter int T_DW_NS  = 8,
    parameter int T_AW_NS  = 10,
    parameter int T_AA_NS  = 12,
    parameter int T_OE_NS  = 7,
    parameter int TURN_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int WR_CYC = max3(cyc_of(T_WP_NS, CLK_NS),
                                 cyc_of(T_DW_NS, CLK_NS),
                                 cyc_of(T_AW_NS, CLK_NS));
    localparam int RD_CYC = max3(cyc_of(T_AA_NS, CLK_NS),
                                 cyc_of(T_OE_NS, CLK_NS), 1);
    localparam int CNT_W  = $clog2(max3(WR_CYC, RD_CYC, TURN_CYC) + 1);

    pin_ctl_t         ctl;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             capture;

    asram_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYC(WR_CYC),
        .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .tmr_last(tmr_last),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .capture(capture),
        .ctl_q(ctl), .addr_q(mem_addr), .wdata_q(mem_dq_o)
    );

    asram_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .last(tmr_last)
    );

    asram_rdcap #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .din(mem_dq_i), .dout(rd_data)
    );

    assign mem_ce_n  = ctl.ce_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_dq_oe = ctl.drv;
    assign done      = ctl.done;
endmodule

// File: rtl/asram_port_chk.sv
// Pin protocol checker for asram_port, attached by bind.
// Watches only the memory-side pins and done; assumes TURN_CYC of at least 1.
module asram_port_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R5
    AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> (!mem_we_n && !mem_ce_n)); // R3
    AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr))); // R2
    AST_WE_END_HELD: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_addr) && !mem_dq_oe)); // R2
    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_oe_n); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_READ_TURN: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_oe_n) |=> (mem_ce_n && mem_oe_n && !mem_dq_oe)); // R7
    AST_ADDR_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n) |-> $stable(mem_addr)); // R9
    AST_ADDR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n) (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr)); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o)); // R11
endmodule

bind asram_port asram_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_asram_port.sv
module sim_asram_port;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int TURN = 1;

    // Expected phase lengths from R10, computed here independently.
    function automatic int ceil1(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int WR_EXP = (ceil1(9) > ceil1(8)) ?
                            ((ceil1(9) > ceil1(10)) ? ceil1(9) : ceil1(10)) :
                            ((ceil1(8) > ceil1(10)) ? ceil1(8) : ceil1(10));
    localparam int RD_EXP = (ceil1(12) > ceil1(7)) ? ceil1(12) : ceil1(7);

    logic          clk, rst_n, req, req_wr, done;
    logic [AW-1:0] req_addr, mem_addr;
    logic [DW-1:0] req_wdata, rd_data, mem_dq_o, mem_dq_i;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

    typedef struct {
        bit          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;
    item_t exp_q[$];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    asram_port #(.CLK_NS(CLK_PERIOD), .TURN_CYC(TURN)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Memory model: data valid only after output enable has been low two sampled cycles.
    logic [DW-1:0] mem [int];
    int oe_age = 0;
    always @(negedge clk) begin
        if (mem_ce_n || mem_oe_n) oe_age = 0;
        else oe_age = oe_age + 1;
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_o;
        if (!mem_ce_n && !mem_oe_n && mem_we_n && oe_age >= 2)
            mem_dq_i = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_i = 8'hEE;
    end

    // Monitor: per-cycle pin checks and scoreboard compare on done.
    logic prev_we_n = 1'b1, prev_ce_n = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                chk(!mem_ce_n && mem_oe_n, "R2", "ce/oe during strobe", {mem_ce_n, mem_oe_n}, 2'b01);
                chk(mem_dq_oe, "R3", "drive during strobe", mem_dq_oe, 1);
                if (exp_q.size() > 0) begin
                    chk(mem_addr == exp_q[0].addr, "R9", "addr in write", mem_addr, exp_q[0].addr);
                    chk(mem_dq_o == exp_q[0].data, "R3", "write byte", mem_dq_o, exp_q[0].data);
                end
                if (prev_we_n) chk(!prev_ce_n, "R2", "setup cycle before strobe", prev_ce_n, 0);
            end else begin
                chk(!mem_dq_oe, "R3", "drive outside strobe", mem_dq_oe, 0);
            end
            if (!mem_oe_n) begin
                chk(mem_we_n && !mem_dq_oe, "R5", "read pins", {mem_we_n, mem_dq_oe}, 2'b10);
                if (exp_q.size() > 0)
                    chk(mem_addr == exp_q[0].addr, "R9", "addr in read", mem_addr, exp_q[0].addr);
            end
            if (!prev_we_n && mem_we_n) begin
                chk(!mem_ce_n && done, "R2", "end cycle after strobe", {mem_ce_n, done}, 2'b01);
                if (exp_q.size() > 0)
                    chk(mem_addr == exp_q[0].addr, "R9", "addr after strobe", mem_addr, exp_q[0].addr);
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "done without accepted request", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    if (it.rd) begin
                        chk(rd_data == it.data, "R4", "read byte", rd_data, it.data);
                        chk(mem_oe_n, "R6", "oe high at read done", mem_oe_n, 1);
                    end else begin
                        chk(mem.exists(int'(it.addr)) && mem[int'(it.addr)] == it.data,
                            "R6", "byte stored at write done",
                            mem.exists(int'(it.addr)) ? mem[int'(it.addr)] : 0, it.data);
                    end
                end
            end
            prev_we_n = mem_we_n;
            prev_ce_n = mem_ce_n;
        end
    end

    // Driver: issue one request, time done, wait out the cycle.
    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit intrude);
        item_t it;
        int lat;
        it.rd = !wr;
        it.addr = a;
        it.data = d;
        exp_q.push_back(it);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        if (intrude) begin
            req = 1'b1; req_wr = 1'b1; req_addr = a ^ 15'h0001; req_wdata = ~d;
        end
        while (!done) begin
            @(negedge clk);
            req = 1'b0;
            lat++;
        end
        if (wr) chk(lat == 2 + WR_EXP, "R10", "write latency", lat, 2 + WR_EXP);
        else    chk(lat == 1 + RD_EXP, "R10", "read latency", lat, 1 + RD_EXP);
        if (intrude) begin
            req = 1'b1; req_wr = 1'b1; req_addr = a ^ 15'h0002; req_wdata = ~d;
        end
        @(negedge clk);
        req = 1'b0;
        chk(!done, "R6", "done single cycle", done, 0);
        if (!wr) begin
            chk(mem_ce_n && mem_oe_n && !mem_dq_oe, "R7", "turnaround idle",
                {mem_ce_n, mem_oe_n, mem_dq_oe}, 3'b110);
            repeat (TURN) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done, "R1", "reset pins",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, done}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done, "R1", "first idle cycle",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, done}, 5'b11100);
        // R2 R3 writes with several patterns, including the address extremes
        do_op(1, 15'h0000, 8'hA5, 0);
        do_op(1, 15'h7FFF, 8'h5A, 0);
        do_op(1, 15'h1234, 8'hFF, 0);
        do_op(1, 15'h4321, 8'h00, 0);
        // R4 reads back
        do_op(0, 15'h0000, 8'hA5, 0);
        do_op(0, 15'h7FFF, 8'h5A, 0);
        do_op(0, 15'h1234, 8'hFF, 0);
        do_op(0, 15'h4321, 8'h00, 0);
        // R7 read followed directly by a write, then read back
        do_op(0, 15'h1234, 8'hFF, 0);
        do_op(1, 15'h1234, 8'h3C, 0);
        do_op(0, 15'h1234, 8'h3C, 0);
        // R8 requests raised while busy are ignored
        do_op(1, 15'h0100, 8'h77, 1);
        do_op(0, 15'h0100, 8'h77, 1);
        chk(!mem.exists(int'(15'h0101)) && !mem.exists(int'(15'h0102)), "R8",
            "ignored write reached memory", mem.exists(int'(15'h0101)), 0);
        do_op(0, 15'h0101, 8'h00, 0);
        chk(exp_q.size() == 0, "R6", "pending items at end", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule